// File: doc/BRIEF.md
# Parallel Port Forward FIFO Controller

This block is the host side of a parallel printer port that has a byte FIFO in front of the data lines. Software reaches it through a small register bus with four addresses: a FIFO write port, an extended control register, a status register and a reverse-data latch. The control register holds a 3-bit mode field, a DMA enable, a mask for the error interrupt and a sticky service flag. It also reports whether the FIFO is empty or full.

In the forward FIFO mode a strobe engine takes bytes from the FIFO and places each one on the data lines. It waits out a setup time and starts the strobe pulse only while the peripheral's BUSY line is low. It then holds the data for a hold time. The pulse widths are counts of clock cycles set by parameters. A test mode accepts FIFO writes but never sends them, so software can fill the FIFO and count its depth. Any change of the mode field empties the FIFO.

The block raises the service flag for PIO refills when enough of the FIFO is free, or at DMA terminal count when DMA is on. It drives a DMA request while the FIFO can take data. A reverse byte latch captures the peripheral's data lines whenever the host is not driving them.

Top module: `ppfifo_ctrl`

## Requirements
- R1: After reset the control register (address 1) reads 0x31, which is the PS2 mode code 3'b001 in bits 7:5, error mask bit 4 = 1, DMA enable bit 3 = 0, service bit 2 = 0, full bit 1 = 0 and empty bit 0 = 1. Status (address 2) and the reverse latch (address 3) read 0. strobe_out, pd_oe, irq and dma_req are 0.
- R2: Control bit 0 reads 1 exactly when the FIFO holds no byte, and bit 1 reads 1 exactly when it holds DEPTH (16) bytes.
- R3: A FIFO write (address 0) while the FIFO is full is dropped and sets the sticky overflow bit (status bit 0). Writing 1 to status bit 0 clears it.
- R4: A control write whose bits 7:5 differ from the current mode empties the FIFO. FIFO writes in PS2 mode are ignored and do not set the overflow bit.
- R5: In forward FIFO mode (code 3'b010) the bytes leave in write order on pd_out. Each strobe is high for exactly PULSE_CYC cycles, and pd_out has been stable for at least SETUP_CYC cycles when strobe_out rises.
- R6: A strobe pulse starts only on a clock edge where busy_in is sampled low.
- R7: Status bit 1 (done) reads 1 when the forward engine is idle, the FIFO is empty, and busy_in has been seen high after the last byte was taken. It reads 0 while bytes are pending or if BUSY never rose.
- R8: In forward mode with DMA off, service bit 2 is set in every cycle in which at least THRESH (8) FIFO slots are free. Writing 0 to bit 2 clears it only when that condition no longer holds, and writing 1 leaves it unchanged.
- R9: With DMA enabled, the free-slot condition does not set the service flag, and a pulse on dma_tc does. dma_req is 1 when DMA is on, the mode is forward, the FIFO is not full and the service flag is clear.
- R10: irq is 1 when the service flag is set, or when fault_in is 1 while error mask bit 4 is 0.
- R11: pd_oe is 1 only in forward mode. While pd_oe is 0, a rising ack_in captures pd_in into the reverse latch. While pd_oe is 1, the latch keeps its value.
- R12: In test mode (code 3'b110) FIFO writes are stored but no strobe is ever produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 FIFO, 1 control, 2 status, 3 reverse latch |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on bus_addr) |
| pd_out | output | 8 | Data lines driven toward the peripheral |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data lines seen from the peripheral |
| strobe_out | output | 1 | Data strobe pulse, active high |
| busy_in | input | 1 | Peripheral BUSY, active high |
| ack_in | input | 1 | Peripheral acknowledge, capture on rising edge |
| fault_in | input | 1 | Peripheral error indication, active high |
| dma_tc | input | 1 | DMA terminal-count pulse |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The assertions treat busy_in, ack_in, fault_in and dma_tc as synchronous to clk. They assume at most one register write per cycle. The pulse-width property assumes that a strobe which stops early comes only from a mode change out of forward mode. The bench's peripheral model changes its inputs on the falling clock edge. It raises BUSY for a random 1 to 5 cycles after each strobe, or holds it high on request to stall the engine. Forward bursts are never longer than the FIFO, so overflow is only provoked on purpose in test mode.

// File: rtl/ppfc_pkg.sv
package ppfc_pkg;

    localparam int DW = 8;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_PS2  = 3'b001;
    localparam mode_t MODE_FWD  = 3'b010;
    localparam mode_t MODE_ECP  = 3'b011;
    localparam mode_t MODE_TEST = 3'b110;

    localparam logic [1:0] RA_FIFO = 2'd0;
    localparam logic [1:0] RA_CTRL = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
    localparam logic [1:0] RA_RLAT = 2'd3;

    // Read view of the control register, bit 7 down to bit 0
    typedef struct packed {
        mode_t mode;
        logic  err_mask;
        logic  dma_en;
        logic  service;
        logic  full;
        logic  empty;
    } ctrl_view_t;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       done;
        logic       ovf;
    } stat_view_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SETUP,
        ENG_PULSE,
        ENG_HOLD
    } eng_state_e;

    function automatic logic mode_takes_fifo(input mode_t m);
        return (m == MODE_FWD) || (m == MODE_ECP) || (m == MODE_TEST);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ppfc_fifo.sv
module ppfc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic                           push,
    input  logic [W-1:0]                   wdata,
    input  logic                           pop,
    output logic [W-1:0]                   rdata,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CNTW-1:0] cnt_q;
    logic do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/ppfc_strobe_eng.sv
module ppfc_strobe_eng
    import ppfc_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          abort,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_rdata,
    input  logic          busy_in,
    output logic          pop,
    output logic [DW-1:0] pd_out,
    output logic          strobe,
    output logic          done
);
    localparam int CW = $clog2(max3(SETUP_CYC, PULSE_CYC, HOLD_CYC) + 1);
    localparam logic [CW-1:0] LD_SETUP = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LD_PULSE = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);

    eng_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] pd_q;
    logic          busy_seen_q;
    logic          live;

    assign live   = run && !abort;
    assign pop    = live && (state_q == ENG_IDLE) && !fifo_empty;
    assign strobe = (state_q == ENG_PULSE);
    assign pd_out = pd_q;
    assign done   = run && (state_q == ENG_IDLE) && fifo_empty && busy_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ENG_IDLE;
            cnt_q       <= '0;
            pd_q        <= '0;
            busy_seen_q <= 1'b0;
        end else if (!live) begin
            state_q     <= ENG_IDLE;
            cnt_q       <= '0;
            busy_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (!fifo_empty) begin
                        pd_q        <= fifo_rdata;
                        cnt_q       <= LD_SETUP;
                        busy_seen_q <= 1'b0;
                        state_q     <= ENG_SETUP;
                    end else if (busy_in) begin
                        busy_seen_q <= 1'b1;
                    end
                end
                ENG_SETUP: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (!busy_in) begin
                        cnt_q   <= LD_PULSE;
                        state_q <= ENG_PULSE;
                    end
                end
                ENG_PULSE: begin
                    if (busy_in) busy_seen_q <= 1'b1;
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        cnt_q   <= LD_HOLD;
                        state_q <= ENG_HOLD;
                    end
                end
                default: begin
                    if (busy_in) busy_seen_q <= 1'b1;
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else begin
                        state_q <= ENG_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ppfc_regs.sv
module ppfc_regs
    import ppfc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  addr,
    input  logic [DW-1:0]               wdata,
    input  logic                        fifo_empty,
    input  logic                        fifo_full,
    input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
    input  logic                        eng_done,
    input  logic                        dma_tc,
    input  logic                        fault_in,
    input  logic                        ack_in,
    input  logic [DW-1:0]               pd_in,
    output mode_t                       mode,
    output logic                        flush,
    output logic                        push,
    output logic                        ovf_flag,
    output logic                        pd_oe,
    output logic [DW-1:0]               rdata,
    output logic                        irq,
    output logic                        dma_req
);
    mode_t         mode_q;
    logic          mask_q, dma_q, svc_q, ovf_q, ack_q;
    logic [DW-1:0] rlat_q;
    logic          wr_fifo, wr_ctrl, wr_stat;
    logic          push_req, svc_set, svc_clr;
    logic          free_ok;
    logic          unused_wbit;
    ctrl_view_t    cview;
    stat_view_t    sview;

    assign unused_wbit = wdata[1];

    assign wr_fifo  = wr_en && (addr == RA_FIFO);
    assign wr_ctrl  = wr_en && (addr == RA_CTRL);
    assign wr_stat  = wr_en && (addr == RA_STAT);

    assign push_req = wr_fifo && mode_takes_fifo(mode_q);
    assign push     = push_req && !fifo_full;
    assign flush    = wr_ctrl && (wdata[7:5] != mode_q);

    assign free_ok  = (DEPTH - int'(fifo_count)) >= THRESH;
    assign svc_set  = ((mode_q == MODE_FWD) && !dma_q && free_ok) || (dma_q && dma_tc);
    assign svc_clr  = wr_ctrl && !wdata[2];

    assign mode     = mode_q;
    assign ovf_flag = ovf_q;
    assign pd_oe    = (mode_q == MODE_FWD);
    assign irq      = svc_q || (fault_in && !mask_q);
    assign dma_req  = dma_q && (mode_q == MODE_FWD) && !fifo_full && !svc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PS2;
            mask_q <= 1'b1;
            dma_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= wdata[7:5];
            mask_q <= wdata[4];
            dma_q  <= wdata[3];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= 1'b0;
        end else if (svc_set) begin
            svc_q <= 1'b1;
        end else if (svc_clr) begin
            svc_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (push_req && fifo_full) begin
            ovf_q <= 1'b1;
        end else if (wr_stat && wdata[0]) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            rlat_q <= '0;
        end else begin
            ack_q <= ack_in;
            if (ack_in && !ack_q && !pd_oe) begin
                rlat_q <= pd_in;
            end
        end
    end

    always_comb begin
        cview.mode     = mode_q;
        cview.err_mask = mask_q;
        cview.dma_en   = dma_q;
        cview.service  = svc_q;
        cview.full     = fifo_full;
        cview.empty    = fifo_empty;
        sview.rsvd     = '0;
        sview.done     = eng_done;
        sview.ovf      = ovf_q;
        case (addr)
            RA_CTRL: rdata = cview;
            RA_STAT: rdata = sview;
            RA_RLAT: rdata = rlat_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppfifo_ctrl.sv
module ppfifo_ctrl
    import ppfc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int THRESH    = 8,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    input  logic [7:0] pd_in,
    output logic       strobe_out,
    input  logic       busy_in,
    input  logic       ack_in,
    input  logic       fault_in,
    input  logic       dma_tc,
    output logic       irq,
    output logic       dma_req
);
    localparam int CNTW = $clog2(DEPTH+1);

    mode_t           mode_q;
    logic            flush, push, pop;
    logic            fifo_empty, fifo_full, eng_done, ovf_flag;
    logic [CNTW-1:0] fifo_count;
    logic [DW-1:0]   fifo_rdata;

    ppfc_fifo #(.DEPTH(DEPTH), .W(DW)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (push),
        .wdata (bus_wdata),
        .pop   (pop),
        .rdata (fifo_rdata),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ppfc_regs #(.DEPTH(DEPTH), .THRESH(THRESH)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .fifo_count (fifo_count),
        .eng_done   (eng_done),
        .dma_tc     (dma_tc),
        .fault_in   (fault_in),
        .ack_in     (ack_in),
        .pd_in      (pd_in),
        .mode       (mode_q),
        .flush      (flush),
        .push       (push),
        .ovf_flag   (ovf_flag),
        .pd_oe      (pd_oe),
        .rdata      (bus_rdata),
        .irq        (irq),
        .dma_req    (dma_req)
    );

    ppfc_strobe_eng #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) eng_i (
        .clk        (clk),
        .rst        (rst),
        .run        (mode_q == MODE_FWD),
        .abort      (flush),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .busy_in    (busy_in),
        .pop        (pop),
        .pd_out     (pd_out),
        .strobe     (strobe_out),
        .done       (eng_done)
    );
endmodule

// File: rtl/ppfifo_ctrl_chk.sv
module ppfifo_ctrl_chk
    import ppfc_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic [1:0]                 bus_addr,
    input logic [7:0]                 bus_wdata,
    input logic                       busy_in,
    input logic                       strobe_out,
    input logic [7:0]                 pd_out,
    input logic                       pd_oe,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count,
    input mode_t                      cur_mode,
    input logic                       ovf_flag
);
    logic [7:0] stab_cnt, hi_cnt, pd_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stab_cnt <= '0;
            hi_cnt   <= '0;
            pd_prev  <= '0;
        end else begin
            pd_prev <= pd_out;
            if (pd_out != pd_prev) stab_cnt <= 8'd1;
            else if (stab_cnt != 8'hff) stab_cnt <= stab_cnt + 1'b1;
            if (!strobe_out) hi_cnt <= '0;
            else if (hi_cnt != 8'hff) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_count) <= DEPTH);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_FIFO && mode_takes_fifo(cur_mode) && int'(fifo_count) == DEPTH)
        |=> ovf_flag);

    assert_mode_flush_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_CTRL && bus_wdata[7:5] != cur_mode) |=> fifo_count == '0);

    assert_ps2_ignore_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_FIFO && cur_mode == MODE_PS2) |=> $stable(fifo_count));

    assert_setup_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_out) |-> int'(stab_cnt) >= SETUP_CYC);

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe_out) && pd_oe) |-> int'(hi_cnt) == PULSE_CYC);

    assert_busy_gate_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_out) |-> !$past(busy_in));

    assert_test_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == MODE_TEST) |-> !strobe_out);
endmodule

bind ppfifo_ctrl ppfifo_ctrl_chk #(
    .DEPTH     (DEPTH),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .busy_in    (busy_in),
    .strobe_out (strobe_out),
    .pd_out     (pd_out),
    .pd_oe      (pd_oe),
    .fifo_count (fifo_count),
    .cur_mode   (mode_q),
    .ovf_flag   (ovf_flag)
);

// File: tb/ppfifo_ctrl_tb_top.sv
module ppfifo_ctrl_tb_top;
    import ppfc_pkg::*;

    localparam int DEPTH = 16;
    localparam int PULSE = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, pd_out, pd_in;
    logic       pd_oe, strobe_out, busy_in, ack_in, fault_in, dma_tc, irq, dma_req;

    int n_checks = 0;
    int n_fail   = 0;
    int nstrobe  = 0;
    logic force_busy = 1'b0;
    logic quiet      = 1'b0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    ppfifo_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out),
        .pd_oe(pd_oe), .pd_in(pd_in), .strobe_out(strobe_out),
        .busy_in(busy_in), .ack_in(ack_in), .fault_in(fault_in),
        .dma_tc(dma_tc), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_word(input mode_t m, input logic mask,
                                             input logic dma, input logic keep_svc);
        return {m, mask, dma, keep_svc, 2'b00};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic send(input logic [7:0] d);
        exp_q.push_back(d);
        wr(RA_FIFO, d);
    endtask

    task automatic wait_done(output logic ok);
        logic [7:0] s;
        ok = 1'b0;
        for (int i = 0; i < 3000 && !ok; i++) begin
            rd(RA_STAT, s);
            if (s[1]) ok = 1'b1;
        end
    endtask

    // Peripheral model: checks strobes, answers with BUSY
    initial begin : periph
        logic stb_prev;
        int   busy_cnt, hi_len;
        stb_prev = 1'b0; busy_cnt = 0; hi_len = 0;
        busy_in  = 1'b0;
        forever begin
            @(negedge clk);
            if (strobe_out && !stb_prev) begin
                nstrobe++;
                chk("R6 busy low at strobe start", {31'd0, busy_in}, 32'd0);
                if (exp_q.size() == 0) chk("R5 unexpected strobe", 32'd1, 32'd0);
                else chk("R5 byte order", {24'd0, pd_out}, {24'd0, exp_q.pop_front()});
                hi_len = 1;
                if (!quiet) busy_cnt = 1 + int'($urandom % 5);
            end else begin
                if (strobe_out) hi_len++;
                else if (stb_prev) chk("R5 strobe width", hi_len, PULSE);
                if (busy_cnt > 0) busy_cnt--;
            end
            busy_in  = force_busy || (busy_cnt > 0);
            stb_prev = strobe_out;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic ok;
        int len, snap;
        void'($urandom(32'd4711));
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        pd_in = '0; ack_in = 1'b0; fault_in = 1'b0; dma_tc = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(RA_CTRL, d); chk("R1 ctrl reset", d, 8'h31);
        rd(RA_STAT, d); chk("R1 status reset", d, 8'h00);
        rd(RA_RLAT, d); chk("R1 rlatch reset", d, 8'h00);
        chk("R1 outputs reset", {strobe_out, pd_oe, irq, dma_req}, 4'b0000);

        // R11 reverse latch capture while not driving
        @(negedge clk); pd_in = 8'hA5; ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
        rd(RA_RLAT, d); chk("R11 capture in PS2", d, 8'hA5);

        // R10 error interrupt masking
        @(negedge clk); fault_in = 1'b1;
        #1 chk("R10 fault masked", irq, 1'b0);
        wr(RA_CTRL, ctrl_word(MODE_PS2, 1'b0, 1'b0, 1'b1));
        #1 chk("R10 fault unmasked", irq, 1'b1);
        @(negedge clk); fault_in = 1'b0;
        #1 chk("R10 fault gone", irq, 1'b0);
        wr(RA_CTRL, ctrl_word(MODE_PS2, 1'b1, 1'b0, 1'b1));

        // R2 R3 R12 test mode depth measurement
        snap = nstrobe;
        wr(RA_CTRL, ctrl_word(MODE_TEST, 1'b1, 1'b0, 1'b1));
        for (int i = 0; i < DEPTH - 1; i++) wr(RA_FIFO, 8'(i));
        rd(RA_CTRL, d); chk("R2 one short of full", d[1:0], 2'b00);
        wr(RA_FIFO, 8'hEE);
        rd(RA_CTRL, d); chk("R2 full at depth", d[1:0], 2'b10);
        chk("R8 no service in test mode", d[2], 1'b0);
        rd(RA_STAT, d); chk("R3 no overflow yet", d[0], 1'b0);
        wr(RA_FIFO, 8'hEF);
        rd(RA_STAT, d); chk("R3 overflow sticky", d[0], 1'b1);
        rd(RA_CTRL, d); chk("R3 still full", d[1:0], 2'b10);
        repeat (10) @(negedge clk);
        chk("R12 no strobe in test mode", nstrobe, snap);
        wr(RA_STAT, 8'h01);
        rd(RA_STAT, d); chk("R3 overflow cleared", d[0], 1'b0);
        wr(RA_CTRL, ctrl_word(MODE_PS2, 1'b1, 1'b0, 1'b1));
        rd(RA_CTRL, d); chk("R4 flushed on mode change", d[1:0], 2'b01);
        wr(RA_FIFO, 8'h55);
        rd(RA_CTRL, d); chk("R4 PS2 write ignored", d[0], 1'b1);
        rd(RA_STAT, d); chk("R4 PS2 write no overflow", d[0], 1'b0);

        // Forward mode
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        rd(RA_CTRL, d); chk("R8 service with empty FIFO", d[2], 1'b1);
        chk("R11 pd_oe in forward", pd_oe, 1'b1);
        chk("R10 irq from service", irq, 1'b1);
        chk("R9 no dma_req when DMA off", dma_req, 1'b0);
        @(negedge clk); pd_in = 8'h3C; ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
        rd(RA_RLAT, d); chk("R11 latch holds while driving", d, 8'hA5);

        // Random bursts
        for (int b = 0; b < 8; b++) begin
            len = 1 + int'($urandom % DEPTH);
            for (int i = 0; i < len; i++) send(8'($urandom));
            if (b == 0) begin
                rd(RA_STAT, d); chk("R7 not done while pending", d[1], 1'b0);
            end
            wait_done(ok);
            chk("R7 done after burst", ok, 1'b1);
            rd(RA_CTRL, d); chk("R2 empty after drain", d[0], 1'b1);
            chk("R5 all bytes strobed", exp_q.size(), 0);
        end

        // R8 threshold boundary with stalled engine
        repeat (10) @(negedge clk);
        force_busy = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < DEPTH/2 + 1; i++) send(8'hA0 + 8'(i));
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b0, 1'b0));
        rd(RA_CTRL, d); chk("R8 clear blocked at 8 free", d[2], 1'b1);
        send(8'hB9);
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b0, 1'b0));
        rd(RA_CTRL, d); chk("R8 clear at 7 free", d[2], 1'b0);
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b0, 1'b1));
        rd(RA_CTRL, d); chk("R8 write 1 no effect", d[2], 1'b0);
        force_busy = 1'b0;
        wait_done(ok);
        chk("R7 done after stall", ok, 1'b1);
        rd(RA_CTRL, d); chk("R8 service back after drain", d[2], 1'b1);
        chk("R5 stalled bytes strobed", exp_q.size(), 0);

        // R7 BUSY never rises
        repeat (10) @(negedge clk);
        quiet = 1'b1;
        send(8'h77);
        repeat (40) @(negedge clk);
        chk("R5 quiet byte strobed", exp_q.size(), 0);
        rd(RA_STAT, d); chk("R7 no done without BUSY", d[1], 1'b0);
        quiet = 1'b0;

        // R9 DMA
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b1, 1'b1));
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b1, 1'b0));
        repeat (3) @(negedge clk);
        rd(RA_CTRL, d); chk("R9 no threshold service with DMA", d[2], 1'b0);
        chk("R9 dma_req asserted", dma_req, 1'b1);
        @(negedge clk); dma_tc = 1'b1;
        @(negedge clk); dma_tc = 1'b0;
        rd(RA_CTRL, d); chk("R9 service at terminal count", d[2], 1'b1);
        chk("R9 dma_req drops on service", dma_req, 1'b0);
        chk("R10 irq at terminal count", irq, 1'b1);
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b1, 1'b0));
        rd(RA_CTRL, d); chk("R9 service cleared", d[2], 1'b0);

        // R4 flush of pending forward bytes
        wr(RA_CTRL, ctrl_word(MODE_FWD, 1'b1, 1'b0, 1'b1));
        force_busy = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) send(8'hC0 + 8'(i));
        snap = nstrobe;
        wr(RA_CTRL, ctrl_word(MODE_TEST, 1'b1, 1'b0, 1'b1));
        exp_q.delete();
        rd(RA_CTRL, d); chk("R4 forward bytes flushed", d[1:0], 2'b01);
        force_busy = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 no strobe after flush", nstrobe, snap);
        chk("R11 pd_oe off in test", pd_oe, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule